// File: doc/BRIEF.md
# Banked Interrupt Controller with Round-Robin Pending Index

This block gathers 128 interrupt sources into four banks of 32 and presents them to a processor through a 32-bit register bus. A rising edge on a source latches a status bit. Software acknowledges a source by writing ones to a bank's clear register. A per-source enable bit gates the source towards the processor. A per-source route bit sends it either to the normal interrupt output or to the fast-interrupt output.

To pick the next source to service, software reads a next-pending register. The hardware searches the latched status bits for the first set bit. The search starts one position after the source last handed out and wraps around all 128 sources, so a busy source cannot starve the others. Each read that returns a valid source moves the search start past that source.

The bus is a single-cycle register port. Read data is combinational from `bus_addr`. A write takes effect at the clock edge where `bus_wr` is high.

Top module: `banked_intc`

## Requirements
- R1: After reset, all enable bits, route bits and status bits are 0, both processor outputs are low, and the next-pending register reads 0.
- R2: Bank k occupies byte addresses 16k to 16k+15, for k = 0 to 3. Within a bank the word at +0 is status (read-only), +4 is clear (write-only, reads 0), +8 is enable and +12 is route. Source n uses bank n>>5 and bit n&31. The next-pending register is at byte address 0x40.
- R3: Writing a 1 to a clear bit drops the matching status bit. Clear bits written as 0 leave status untouched, and writing all ones empties the bank.
- R4: A source whose input was low at the previous clock edge and is high at this edge has its status bit set at this edge. A level held high sets status only once. When a set and a clear of the same bit meet at one edge, the bit ends up set.
- R5: `irq` is high exactly when some source has status 1, enable 1 and route 0. A source with enable 0 drives neither output.
- R6: `fiq` is high exactly when some source has status 1, enable 1 and route 1.
- R7: A read of 0x40 returns bit 31 = 1 and bits 6:0 = the index of the first set status bit, searching upward from (last+1) mod 128 and wrapping back to last itself. All other bits are 0. With no status bit set, the read returns 0.
- R8: last resets to 127, so the first search starts at source 0. last takes the returned index at the edge of every read of 0x40 that returns bit 31 = 1.
- R9: Reads of any other address, and of misaligned addresses, return 0. Writes to status words, to 0x40 or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 128 | Interrupt source inputs, bit n is source n |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances the search start on a next-pending read) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The one same-cycle interaction is a new rising edge on a source at the very edge where software writes a 1 to that source's clear bit. The bench raises the source and issues the clear write in the same cycle. It then judges the result by reading the bank status and expecting the bit still set. A plain clear that follows must then drop the bit, and the source, still held high, must not set it again.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // word slot within a bank (byte address bits 3:2)
  typedef enum logic [1:0] {
    SLOT_STAT  = 2'd0,
    SLOT_CLR   = 2'd1,
    SLOT_EN    = 2'd2,
    SLOT_ROUTE = 2'd3
  } slot_e;

  // a latched bit survives unless cleared; a new edge always wins
  function automatic logic [31:0] next_status(input logic [31:0] cur,
                                              input logic [31:0] clr,
                                              input logic [31:0] rise);
    return (cur & ~clr) | rise;
  endfunction
endpackage

// File: rtl/intc_edge.sv
module intc_edge #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src_i;
  end

  assign rise_o = src_i & ~prev_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic         we_clr,
  input  logic         we_en,
  input  logic         we_route,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] route_o,
  output logic         irq_o,
  output logic         fiq_o
);
  logic [W-1:0] status_q, enable_q, route_q;
  logic [W-1:0] clr_bits;

  assign clr_bits = we_clr ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      route_q  <= '0;
    end else begin
      status_q <= next_status(status_q, clr_bits, rise_i);
      if (we_en)    enable_q <= wdata_i;
      if (we_route) route_q  <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign route_o  = route_q;
  assign irq_o    = |(status_q & enable_q & ~route_q);
  assign fiq_o    = |(status_q & enable_q & route_q);

  // R4: every rising edge is latched at its own clock edge
  p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((status_q & $past(rise_i)) == $past(rise_i)));

  // R3: cleared bits without a competing edge are gone afterwards
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((status_q & $past(wdata_i & ~rise_i)) == '0));
endmodule

// File: rtl/intc_rr.sv
module intc_rr #(
  parameter int N     = 128,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     status_i,
  input  logic             adv_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] last_q;

  // first set bit at or after start, wrapping; N must be 2**IDX_W
  function automatic logic [IDX_W:0] rr_find(input logic [N-1:0] st,
                                             input logic [IDX_W-1:0] last);
    logic [IDX_W-1:0] j;
    logic [IDX_W:0]   res;
    res = '0;
    for (int k = N; k >= 1; k--) begin
      j = last + IDX_W'(k);
      if (st[j]) res = {1'b1, j};
    end
    return res;
  endfunction

  logic [IDX_W:0] hit;
  assign hit     = rr_find(status_i, last_q);
  assign valid_o = hit[IDX_W];
  assign idx_o   = hit[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                last_q <= IDX_W'(N - 1);
    else if (adv_i && valid_o) last_q <= idx_o;
  end

  // R7: a reported source is really pending
  p_hit_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> status_i[idx_o]);
  // R7: nothing reported only when nothing pending
  p_none_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (status_i == '0));
  // R8: the search start follows each serviced read
  p_last_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && valid_o) |=> (last_q == $past(idx_o)));
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import intc_pkg::*;
#(
  parameter int          NUM_BANKS = 4,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  NP_ADDR   = 8'h40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*DATA_W-1:0]   src_i,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          irq,
  output logic                          fiq
);
  localparam int N      = NUM_BANKS * DATA_W;
  localparam int IDX_W  = $clog2(N);
  localparam int BSEL_W = $clog2(NUM_BANKS);

  logic [N-1:0]        rise;
  logic [N-1:0]        status_flat;
  logic [DATA_W-1:0]   stat_b  [NUM_BANKS];
  logic [DATA_W-1:0]   en_b    [NUM_BANKS];
  logic [DATA_W-1:0]   route_b [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_b, fiq_b;

  // address decode
  logic [ADDR_W-5:0] bank_field;
  logic [BSEL_W-1:0] bsel;
  slot_e             slot;
  logic              aligned, in_banks, np_hit;

  assign bank_field = bus_addr[ADDR_W-1:4];
  assign bsel       = bank_field[BSEL_W-1:0];
  assign slot       = slot_e'(bus_addr[3:2]);
  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign in_banks   = aligned && (int'(bank_field) < NUM_BANKS);
  assign np_hit     = (bus_addr == ADDR_W'(NP_ADDR));

  intc_edge #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_me;
    assign sel_me = bus_wr && in_banks && (bsel == BSEL_W'(b));

    intc_bank #(.W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rise_i(rise[b*DATA_W +: DATA_W]),
      .we_clr(sel_me && slot == SLOT_CLR),
      .we_en(sel_me && slot == SLOT_EN),
      .we_route(sel_me && slot == SLOT_ROUTE),
      .wdata_i(bus_wdata),
      .status_o(stat_b[b]), .enable_o(en_b[b]), .route_o(route_b[b]),
      .irq_o(irq_b[b]), .fiq_o(fiq_b[b])
    );
    assign status_flat[b*DATA_W +: DATA_W] = stat_b[b];
  end

  logic             np_valid;
  logic [IDX_W-1:0] np_idx;

  intc_rr #(.N(N), .IDX_W(IDX_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .status_i(status_flat),
    .adv_i(bus_rd && np_hit), .valid_o(np_valid), .idx_o(np_idx)
  );

  always_comb begin
    bus_rdata = '0;
    if (in_banks) begin
      unique case (slot)
        SLOT_STAT:  bus_rdata = stat_b[bsel];
        SLOT_EN:    bus_rdata = en_b[bsel];
        SLOT_ROUTE: bus_rdata = route_b[bsel];
        default:    bus_rdata = '0;
      endcase
    end else if (np_hit && np_valid) begin
      bus_rdata[DATA_W-1]  = 1'b1;
      bus_rdata[IDX_W-1:0] = np_idx;
    end
  end

  assign irq = |irq_b;
  assign fiq = |fiq_b;

  // R5/R6: an output is never raised with no pending source at all
  p_out_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || fiq) |-> np_valid);
  // R9: the clear slot never reads back
  p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_banks && slot == SLOT_CLR) |-> (bus_rdata == '0));
endmodule

// File: tb/banked_intc_test.sv
`timescale 1ns/1ps
module banked_intc_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src = '0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq, fiq;
  int           n_checks = 0, n_errs = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  banked_intc uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .fiq(fiq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); src[n] = 1'b1;
    @(negedge clk); src[n] = 1'b0;
  endtask

  // op: 0 write, 1 read and compare, 2 pulse source data[6:0], 3 compare {fiq,irq}
  localparam int NV = 31;
  localparam logic [73:0] VEC [NV] = '{
    {2'd1, 8'h08, 32'h0, 32'h0},                 // R1 enable reset
    {2'd0, 8'h08, 32'h1, 32'h0},                 // R2 enable bank0
    {2'd1, 8'h08, 32'h0, 32'h1},                 // R2
    {2'd2, 8'h00, 32'd0, 32'h0},                 // R4 source 0
    {2'd1, 8'h00, 32'h0, 32'h1},                 // R4 status
    {2'd3, 8'h00, 32'h0, 32'h1},                 // R5 irq
    {2'd0, 8'h0C, 32'h1, 32'h0},                 // R6 route to fast
    {2'd3, 8'h00, 32'h0, 32'h2},                 // R6 fiq
    {2'd0, 8'h00, 32'h0, 32'h0},                 // R9 status write ignored
    {2'd1, 8'h00, 32'h0, 32'h1},                 // R9
    {2'd0, 8'h04, 32'h0, 32'h0},                 // R3 zero clear bits
    {2'd1, 8'h00, 32'h0, 32'h1},                 // R3
    {2'd1, 8'h40, 32'h0, 32'h8000_0000},         // R7 idx 0
    {2'd0, 8'h04, 32'h1, 32'h0},                 // R3 clear
    {2'd1, 8'h00, 32'h0, 32'h0},                 // R3
    {2'd3, 8'h00, 32'h0, 32'h0},                 // R6 outputs drop
    {2'd2, 8'h00, 32'd37, 32'h0},                // R2 source 37
    {2'd1, 8'h10, 32'h0, 32'h20},                // R2 bank1 bit5
    {2'd3, 8'h00, 32'h0, 32'h0},                 // R5 disabled source
    {2'd1, 8'h40, 32'h0, 32'h8000_0025},         // R7 idx 37
    {2'd2, 8'h00, 32'd3, 32'h0},                 // source 3
    {2'd1, 8'h40, 32'h0, 32'h8000_0003},         // R8 wrap past 37 to 3
    {2'd1, 8'h40, 32'h0, 32'h8000_0025},         // R8 round robin
    {2'd0, 8'h14, 32'hFFFF_FFFF, 32'h0},         // R3 all ones
    {2'd0, 8'h04, 32'hFFFF_FFFF, 32'h0},         // R3
    {2'd1, 8'h40, 32'h0, 32'h0},                 // R7 none pending
    {2'd0, 8'h50, 32'h1234_5678, 32'h0},         // R9 unmapped write
    {2'd1, 8'h50, 32'h0, 32'h0},                 // R9 unmapped read
    {2'd1, 8'h09, 32'h0, 32'h0},                 // R9 misaligned read
    {2'd2, 8'h00, 32'd127, 32'h0},               // R2 source 127
    {2'd1, 8'h30, 32'h0, 32'h8000_0000}          // R2 bank3 bit31
  };

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs", {30'b0, fiq, irq}, 32'h0);
    bus_read(8'h40, d); check("R1 next-pending", d, 32'h0);
    bus_read(8'h0C, d); check("R1 route", d, 32'h0);
    rst_n = 1'b1;
    check("R1 outputs after release", {30'b0, fiq, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] dv, ev;
      {op, a, dv, ev} = VEC[i];
      case (op)
        2'd0: bus_write(a, dv);
        2'd1: begin bus_read(a, d); check($sformatf("vector %0d", i), d, ev); end
        2'd2: pulse(int'(dv[6:0]));
        default: begin @(negedge clk); check($sformatf("vector %0d outputs", i), {30'b0, fiq, irq}, ev); end
      endcase
    end

    // R5 enable source 127 in bank3 (route 0) -> irq
    bus_write(8'h38, 32'h8000_0000);
    @(negedge clk); check("R5 bank3 irq", {30'b0, fiq, irq}, 32'h1);
    bus_write(8'h34, 32'h8000_0000);
    check("R3 bank3 cleared", {30'b0, fiq, irq}, 32'h0);

    // R4 collision: new edge and clear of the same bit at one edge
    @(negedge clk); src[64] = 1'b1; wr = 1'b1; addr = 8'h24; wdata = 32'h1;
    @(negedge clk); wr = 1'b0;
    bus_read(8'h20, d); check("R4 set wins", d, 32'h1);
    bus_write(8'h24, 32'h1);
    bus_read(8'h20, d); check("R4 held level no re-set", d, 32'h0);
    @(negedge clk); src[64] = 1'b0;

    // R7 wrap back to the start itself with only one pending source
    pulse(0);
    bus_read(8'h40, d); check("R7 single idx0", d, 32'h8000_0000);
    bus_read(8'h40, d); check("R7 full wrap to last", d, 32'h8000_0000);
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_read(8'h00, d); check("R9 write to 0x40 ignored", d, 32'h1);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule